// File: doc/BRIEF.md
# Repeat-Driven FIR and Correlation Tap Engine

This block runs a run of multiply-accumulate taps, one per repeat iteration, for filter and correlation kernels. A single start strobe latches a tap count, a two-bit mode, two data pointers, a coefficient address and the bounds of a circular data buffer. Each tap reads one 16-bit operand from data memory at the first pointer. The second operand comes from coefficient memory or from data memory at the second pointer. The two operands are multiplied as signed values and the product is added into the accumulator.

Filter modes keep a 32-bit sum and spend two cycles per tap. Correlation modes keep a 48-bit sum and spend three cycles per tap. The extra stage lets the product be registered before the wider add. Both memory read ports have one cycle of latency. Data pointers move in 2-byte steps and wrap inside the buffer. The coefficient address moves one word per tap. When the last tap is done, a one-cycle done pulse is given, and the result stays on the output until the next start.

Top module: `tap_mac_engine`

## Requirements
- R1: Mode 2'b00 (filter, coefficient operand) adds dmem[ptr_a] × cmem[coef] on each tap. rd_b_coef_o is 1, and the coefficient address starts at coef_addr_i and grows by 1 per tap without wrapping.
- R2: Mode 2'b01 (filter, data operand) adds dmem[ptr_a] × dmem[ptr_b] on each tap. rd_b_coef_o is 0, and rd_b_addr_o follows the second pointer.
- R3: In filter modes the sum wraps modulo 2^32. acc_o[47:32] always equals copies of acc_o[31].
- R4: Correlation modes 2'b10 (coefficient operand) and 2'b11 (data operand) use the same operand sources as R1 and R2, but sum into 48 bits and wrap modulo 2^48.
- R5: Counting the start-sampling edge as edge 1, done_o is high in the cycle after edge 2N+1 in filter modes and after edge 3N+1 in correlation modes, where N = taps_i.
- R6: After each tap, ptr_a_o steps by 2. If the stepped value would reach or pass buf_base_i + buf_len_i, it becomes buf_base_i instead.
- R7: ptr_b_o steps and wraps as in R6 only in modes 2'b01 and 2'b11. In modes 2'b00 and 2'b10 it keeps the value loaded from ptr_b_i.
- R8: Both operands are multiplied as two's-complement values, and the product is sign-extended before it is added.
- R9: done_o lasts exactly one cycle. An accepted start clears the accumulator. While idle, acc_o holds its value until the next start.
- R10: A start strobe while busy_o is high has no effect on the run in progress: its result, timing and pointers are unchanged.
- R11: A start with taps_i = 0 loads the pointers, clears the accumulator and pulses done_o after the start edge without reading any tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| mode_i | input | 2 | Tap mode (bit1 correlation, bit0 data second operand) |
| taps_i | input | CNT_W | Number of taps |
| ptr_a_i | input | ADDR_W | Initial first data pointer (byte address) |
| ptr_b_i | input | ADDR_W | Initial second data pointer (byte address) |
| coef_addr_i | input | ADDR_W | Initial coefficient word address |
| buf_base_i | input | ADDR_W | Circular buffer base (byte address) |
| buf_len_i | input | ADDR_W | Circular buffer length in bytes, even |
| rd_a_addr_o | output | ADDR_W | Data memory read address, first operand |
| rd_a_data_i | input | DATA_W | Data memory read data, one cycle latency |
| rd_b_addr_o | output | ADDR_W | Second operand read address |
| rd_b_coef_o | output | 1 | 1: second read targets coefficient memory |
| rd_b_data_i | input | DATA_W | Second operand read data, one cycle latency |
| ptr_a_o | output | ADDR_W | Current first data pointer |
| ptr_b_o | output | ADDR_W | Current second data pointer |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| acc_o | output | 3*DATA_W | Accumulator |

## Verification
Each of the four modes is run over memory filled with mixed-sign values. This tells apart a wrong operand source, a missing pointer step and an unsigned multiply. The cycle count to done separates the two-cycle and three-cycle schedules. A run of three products of 2^30 is given in both widths: the filter result must wrap negative with sign extension, and the correlation result must stay positive. Further cases are a small buffer that forces repeated wraps on both pointers, a start pulse during a run, and a zero tap count. Together they show the wrap target, that a start while busy changes nothing, and the clearing of the accumulator on an empty run.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [1:0] {
    MODE_FIR_COEF = 2'b00,
    MODE_FIR_DATA = 2'b01,
    MODE_COR_COEF = 2'b10,
    MODE_COR_DATA = 2'b11
  } tap_mode_e;

  localparam int unsigned PTR_STEP = 2;
  localparam int unsigned NUM_PTR  = 2;
endpackage

// File: rtl/tap_seq_ctrl.sv
module tap_seq_ctrl #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] taps_i,
  input  logic             corr_i,
  output logic             load_o,
  output logic             cap_o,
  output logic             tap_end_o,
  output logic             busy_o,
  output logic             done_o
);
  logic             busy_q, done_q, corr_q;
  logic [1:0]       phase_q, last_ph;
  logic [CNT_W-1:0] left_q;

  assign load_o    = start_i && !busy_q;
  assign last_ph   = corr_q ? 2'd2 : 2'd1;
  assign tap_end_o = busy_q && (phase_q == last_ph);
  assign cap_o     = busy_q && (phase_q == 2'd1);
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      corr_q  <= 1'b0;
      phase_q <= 2'd0;
      left_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        corr_q  <= corr_i;
        phase_q <= 2'd0;
        left_q  <= taps_i;
        if (taps_i == '0) done_q <= 1'b1;
        else              busy_q <= 1'b1;
      end else if (busy_q) begin
        if (tap_end_o) begin
          phase_q <= 2'd0;
          left_q  <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          phase_q <= phase_q + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/tap_addr_gen.sv
module tap_addr_gen
  import tap_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              dual_i,
  input  logic [ADDR_W-1:0] ptr_a_i,
  input  logic [ADDR_W-1:0] ptr_b_i,
  input  logic [ADDR_W-1:0] coef_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] len_i,
  output logic [ADDR_W-1:0] ptr_a_o,
  output logic [ADDR_W-1:0] ptr_b_o,
  output logic [ADDR_W-1:0] coef_o
);
  localparam int unsigned EW = ADDR_W + 1;

  logic [ADDR_W-1:0] cur [NUM_PTR];
  logic [ADDR_W-1:0] nxt [NUM_PTR];
  logic [ADDR_W-1:0] init [NUM_PTR];
  logic [NUM_PTR-1:0] adv;
  logic [ADDR_W-1:0] coef_q;
  logic [EW-1:0]     limit;

  assign limit   = EW'(base_i) + EW'(len_i);
  assign init[0] = ptr_a_i;
  assign init[1] = ptr_b_i;
  assign adv[0]  = step_i;
  assign adv[1]  = step_i && dual_i;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic [EW-1:0] sum;
    logic [ADDR_W-1:0] ptr_q;
    assign sum    = EW'(cur[g]) + EW'(PTR_STEP);
    assign nxt[g] = (sum >= limit) ? base_i : sum[ADDR_W-1:0];
    assign cur[g] = ptr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ptr_q <= '0;
      else if (load_i) ptr_q <= init[g];
      else if (adv[g]) ptr_q <= nxt[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 coef_q <= '0;
    else if (load_i)             coef_q <= coef_i;
    else if (step_i && !dual_i)  coef_q <= coef_q + 1'b1;
  end

  assign ptr_a_o = cur[0];
  assign ptr_b_o = cur[1];
  assign coef_o  = coef_q;
endmodule

// File: rtl/tap_mac_dp.sv
module tap_mac_dp #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                corr_i,
  input  logic                cap_i,
  input  logic                acc_en_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  output logic [3*DATA_W-1:0] acc_o
);
  localparam int unsigned PW = 2 * DATA_W;
  localparam int unsigned AW = 3 * DATA_W;

  logic signed [PW-1:0] prod, prod_q;
  logic [PW-1:0]        fir_sum;
  logic [AW-1:0]        acc_q, cor_sum;

  assign prod    = $signed(a_i) * $signed(b_i);
  // filter path: narrow add straight from the multiplier
  assign fir_sum = acc_q[PW-1:0] + prod;
  // correlation path: wide add from the registered product
  assign cor_sum = acc_q + {{DATA_W{prod_q[PW-1]}}, prod_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prod_q <= '0;
    else if (cap_i) prod_q <= prod;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (clear_i)  acc_q <= '0;
    else if (acc_en_i) acc_q <= corr_i ? cor_sum : {{DATA_W{fir_sum[PW-1]}}, fir_sum};
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/tap_mac_engine.sv
module tap_mac_engine
  import tap_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          mode_i,
  input  logic [CNT_W-1:0]    taps_i,
  input  logic [ADDR_W-1:0]   ptr_a_i,
  input  logic [ADDR_W-1:0]   ptr_b_i,
  input  logic [ADDR_W-1:0]   coef_addr_i,
  input  logic [ADDR_W-1:0]   buf_base_i,
  input  logic [ADDR_W-1:0]   buf_len_i,
  output logic [ADDR_W-1:0]   rd_a_addr_o,
  input  logic [DATA_W-1:0]   rd_a_data_i,
  output logic [ADDR_W-1:0]   rd_b_addr_o,
  output logic                rd_b_coef_o,
  input  logic [DATA_W-1:0]   rd_b_data_i,
  output logic [ADDR_W-1:0]   ptr_a_o,
  output logic [ADDR_W-1:0]   ptr_b_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [3*DATA_W-1:0] acc_o
);
  tap_mode_e         mode_q;
  logic [ADDR_W-1:0] base_q, len_q, coef_addr;
  logic              load, cap, tap_end, corr, dual;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_FIR_COEF;
      base_q <= '0;
      len_q  <= '0;
    end else if (load) begin
      mode_q <= tap_mode_e'(mode_i);
      base_q <= buf_base_i;
      len_q  <= buf_len_i;
    end
  end

  assign corr = (mode_q == MODE_COR_COEF) || (mode_q == MODE_COR_DATA);
  assign dual = (mode_q == MODE_FIR_DATA) || (mode_q == MODE_COR_DATA);

  tap_seq_ctrl #(.CNT_W(CNT_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .taps_i    (taps_i),
    .corr_i    (mode_i[1]),
    .load_o    (load),
    .cap_o     (cap),
    .tap_end_o (tap_end),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  tap_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (tap_end),
    .dual_i  (dual),
    .ptr_a_i (ptr_a_i),
    .ptr_b_i (ptr_b_i),
    .coef_i  (coef_addr_i),
    .base_i  (load ? buf_base_i : base_q),
    .len_i   (load ? buf_len_i : len_q),
    .ptr_a_o (ptr_a_o),
    .ptr_b_o (ptr_b_o),
    .coef_o  (coef_addr)
  );

  tap_mac_dp #(.DATA_W(DATA_W)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (load),
    .corr_i   (corr),
    .cap_i    (cap),
    .acc_en_i (tap_end),
    .a_i      (rd_a_data_i),
    .b_i      (rd_b_data_i),
    .acc_o    (acc_o)
  );

  assign rd_a_addr_o = ptr_a_o;
  assign rd_b_addr_o = dual ? ptr_b_o : coef_addr;
  assign rd_b_coef_o = !dual;
endmodule

// File: rtl/tap_mac_engine_chk.sv
module tap_mac_engine_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                busy_o,
  input logic                done_o,
  input logic [1:0]          mode_q,
  input logic [ADDR_W-1:0]   base_q,
  input logic [ADDR_W-1:0]   ptr_a_o,
  input logic [ADDR_W-1:0]   ptr_b_o,
  input logic [3*DATA_W-1:0] acc_o
);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(acc_o));

  a_r3_sign_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q[1] |-> (acc_o[3*DATA_W-1:2*DATA_W] == {DATA_W{acc_o[2*DATA_W-1]}}));

  a_r7_ptr_b_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mode_q[0]) |=> $stable(ptr_b_o));

  a_r6_ptr_a_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (ptr_a_o == $past(ptr_a_o)) ||
               (ptr_a_o == ADDR_W'($past(ptr_a_o) + 2)) ||
               (ptr_a_o == base_q));

  a_r10_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(mode_q) && $stable(base_q));
endmodule

bind tap_mac_engine tap_mac_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .mode_q  (mode_q),
  .base_q  (base_q),
  .ptr_a_o (ptr_a_o),
  .ptr_b_o (ptr_b_o),
  .acc_o   (acc_o)
);

// File: tb/tap_mac_engine_tb.sv
module tap_mac_engine_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [7:0]  taps_i = '0;
  logic [15:0] ptr_a_i = '0, ptr_b_i = '0, coef_addr_i = '0, buf_base_i = '0, buf_len_i = '0;
  logic [15:0] rd_a_addr_o, rd_b_addr_o, ptr_a_o, ptr_b_o;
  logic [15:0] rd_a_data_i, rd_b_data_i;
  logic        rd_b_coef_o, busy_o, done_o;
  logic [47:0] acc_o;

  logic [15:0] dmem [256];
  logic [15:0] cmem [256];
  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  tap_mac_engine u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i), .taps_i(taps_i),
    .ptr_a_i(ptr_a_i), .ptr_b_i(ptr_b_i), .coef_addr_i(coef_addr_i),
    .buf_base_i(buf_base_i), .buf_len_i(buf_len_i),
    .rd_a_addr_o(rd_a_addr_o), .rd_a_data_i(rd_a_data_i),
    .rd_b_addr_o(rd_b_addr_o), .rd_b_coef_o(rd_b_coef_o), .rd_b_data_i(rd_b_data_i),
    .ptr_a_o(ptr_a_o), .ptr_b_o(ptr_b_o), .busy_o(busy_o), .done_o(done_o), .acc_o(acc_o)
  );

  always @(posedge clk_i) begin
    rd_a_data_i <= dmem[rd_a_addr_o[8:1]];
    rd_b_data_i <= rd_b_coef_o ? cmem[rd_b_addr_o[7:0]] : dmem[rd_b_addr_o[8:1]];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int step_ptr(input int p, input int base, input int len);
    return (p + 2 >= base + len) ? base : p + 2;
  endfunction

  // Runs one job, checks timing, result, pointers, then the idle hold.
  task automatic run(input string req, input logic [1:0] m, input int n,
                     input int pa, input int pb, input int base, input int len,
                     input int coef, input bit disturb, output logic [47:0] res);
    longint acc = 0;
    int ap = pa, bp = pb, cp = coef, cnt = 0, exp_cyc;
    logic [47:0] held;
    for (int i = 0; i < n; i++) begin
      longint av = longint'($signed(dmem[(ap >> 1) & 255]));
      longint bv = m[0] ? longint'($signed(dmem[(bp >> 1) & 255]))
                        : longint'($signed(cmem[cp & 255]));
      acc = acc + av * bv;
      acc = m[1] ? longint'($signed(acc[47:0])) : longint'($signed(acc[31:0]));
      ap = step_ptr(ap, base, len);
      if (m[0]) bp = step_ptr(bp, base, len);
      else      cp++;
    end
    exp_cyc = (n == 0) ? 1 : (m[1] ? 3 : 2) * n + 1;
    @(negedge clk_i);
    mode_i = m; taps_i = 8'(n); ptr_a_i = 16'(pa); ptr_b_i = 16'(pb);
    buf_base_i = 16'(base); buf_len_i = 16'(len); coef_addr_i = 16'(coef);
    start_i = 1'b1;
    do begin
      @(negedge clk_i);
      cnt++;
      start_i = 1'b0;
      if (cnt == 1 && n > 0) begin
        chk(rd_b_coef_o == !m[0], m[0] ? "R2" : "R1", rd_b_coef_o, !m[0]);
        chk(rd_a_addr_o == 16'(pa), req, rd_a_addr_o, pa);
      end
      if (disturb && cnt == 2) begin
        start_i = 1'b1; mode_i = ~m; taps_i = 8'd9; ptr_a_i = 16'h0; ptr_b_i = 16'h2;
      end
    end while (!done_o && cnt < 2000);
    chk(cnt == exp_cyc, "R5", cnt, exp_cyc);
    chk(acc_o == acc[47:0], req, acc_o, acc[47:0]);
    chk(ptr_a_o == 16'(ap), "R6", ptr_a_o, ap);
    chk(ptr_b_o == 16'(bp), m[0] ? "R7 step" : "R7 fixed", ptr_b_o, bp);
    held = acc_o;
    res = acc_o;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk(!done_o, "R9 pulse", done_o, 0);
      chk(acc_o == held, "R9 hold", acc_o, held);
    end
  endtask

  task automatic t_reset();
    chk(acc_o == 48'h0 && !done_o && !busy_o, "R9 reset", acc_o, 0);
  endtask

  task automatic t_fir_coef();
    logic [47:0] r;
    run("R1", 2'b00, 5, 'h20, 'h100, 'h20, 'h40, 10, 1'b0, r);
  endtask

  task automatic t_fir_data();
    logic [47:0] r;
    run("R2", 2'b01, 6, 'h40, 'h60, 'h40, 'h40, 0, 1'b0, r);
  endtask

  task automatic t_cor_modes();
    logic [47:0] r;
    run("R4 coef", 2'b10, 4, 'h80, 'h90, 'h80, 'h20, 50, 1'b0, r);
    run("R4 data", 2'b11, 5, 'hA0, 'hB0, 'hA0, 'h20, 0, 1'b0, r);
  endtask

  task automatic t_wrap();
    logic [47:0] r;
    run("R6 wrap", 2'b01, 7, 'hC4, 'hC6, 'hC0, 8, 0, 1'b0, r);
    run("R6 wrap cor", 2'b11, 5, 'hC0, 'hC6, 'hC0, 8, 0, 1'b0, r);
  endtask

  task automatic t_signed();
    logic [47:0] r;
    dmem['h100 >> 1] = 16'h8000; dmem[('h100 >> 1) + 1] = 16'hFFFB; dmem[('h100 >> 1) + 2] = 16'd1234;
    cmem[200] = 16'h7FFF; cmem[201] = 16'hFFF9; cmem[202] = 16'hFFFD;
    run("R8", 2'b00, 3, 'h100, 0, 'h100, 'h20, 200, 1'b0, r);
    chk(r == 48'hFFFF_C000_0000 + 48'(35) - 48'(3702) + 48'h0000_0000_8000,
        "R8 literal", r, 48'hFFFF_C000_0000 + 48'(35) - 48'(3702) + 48'h0000_0000_8000);
  endtask

  task automatic t_overflow();
    logic [47:0] r;
    for (int i = 0; i < 3; i++) begin
      dmem[('h140 >> 1) + i] = 16'h8000;
      cmem[220 + i] = 16'h8000;
    end
    run("R3", 2'b00, 3, 'h140, 0, 'h140, 'h10, 220, 1'b0, r);
    chk(r == 48'hFFFF_C000_0000, "R3 wrap", r, 48'hFFFF_C000_0000);
    run("R4", 2'b10, 3, 'h140, 0, 'h140, 'h10, 220, 1'b0, r);
    chk(r == 48'h0000_C000_0000, "R4 wide", r, 48'h0000_C000_0000);
  endtask

  task automatic t_busy_start();
    logic [47:0] r;
    run("R10", 2'b00, 4, 'h20, 'h30, 'h20, 'h40, 5, 1'b1, r);
    run("R10 cor", 2'b11, 3, 'hA0, 'hA8, 'hA0, 'h20, 0, 1'b1, r);
  endtask

  task automatic t_zero();
    logic [47:0] r;
    run("R11", 2'b01, 0, 'h44, 'h48, 'h40, 'h40, 0, 1'b0, r);
    chk(r == 48'h0, "R11 clear", r, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      dmem[i] = 16'((i * 2731 + 17) ^ (i << 9));
      cmem[i] = 16'(i * 4099 - 30000);
    end
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_fir_coef();
    t_fir_data();
    t_cor_modes();
    t_wrap();
    t_signed();
    t_overflow();
    t_busy_start();
    t_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule